// File: doc/BRIEF.md
# Operating-State Sequencer for a Serial Peripheral Core

This block owns the operating mode of a serial peripheral core. Software places a 2-bit mode code through a register port, and the block steps the core between three steady modes: idle (held in reset), active (shifting) and frozen (paused). A settle flag, read back beside the mode code, is low while a change is taking effect and high once the new mode holds. Software is expected to wait for that flag before and after every mode write.

Leaving the frozen mode for idle is guarded. It needs two clear-code writes in a row; a single clear only arms the exit. A separate software-reset strobe drops the core into idle from any mode at any time. Whenever the core enters idle, the block sends a one-cycle synchronous clear to the FIFOs, the transfer counters and the status flags beside it. The shift engine is enabled only in active mode. In frozen mode it holds its position and the FIFOs keep their contents.

Top module: `opstate_ctrl`

## Requirements
- R1: The readout `stat_rd` carries the mode in bits [1:0] (idle = 0, active = 1, frozen = 3; code 2 is never shown) and the settle flag in bit 2. After hardware reset it reads 3'b100, and `shift_en`, `shift_hold` and `side_clr` are all low.
- R2: With the settle flag high, a write of code 0, 1 or 3 that is allowed from the present mode takes effect at the next clock edge.
- R3: After an accepted mode change the settle flag reads 0 for exactly SETTLE_CYC (default 4) cycles. It then reads 1.
- R4: A mode write that arrives while the settle flag is 0 has no effect. It neither changes the mode nor stretches the settle window.
- R5: A write of the clear code 2 in idle or active mode has no effect, and the settle flag stays 1.
- R6: In frozen mode, one clear-code write leaves the mode at 3 and the settle flag at 1. The next mode write, if it is also code 2, moves the core to idle.
- R7: In frozen mode a write of code 0 has no effect. A write of 1 or 3 that follows a single clear disarms the exit and is carried out as a normal change, so a later exit again needs two clear writes.
- R8: When `swrst_we` is high with `swrst_bit` = 1, the mode goes to idle at the next edge from any mode, even while the settle flag is 0. A settle window starts and a same-cycle mode write is overridden. With `swrst_bit` = 0 the strobe has no effect.
- R9: `side_clr` is high for one cycle, right after the edge that moves the core into idle from active or frozen mode, or after any software reset. A write of 0 while already idle does not raise it.
- R10: `shift_en` is high exactly when the mode is active, and `shift_hold` is high exactly when the mode is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_we | input | 1 | Mode-register write strobe |
| req_code | input | 2 | Mode code written |
| swrst_we | input | 1 | Software-reset register write strobe |
| swrst_bit | input | 1 | Data bit of the software-reset write |
| stat_rd | output | 3 | {settle flag, mode code} readout |
| shift_en | output | 1 | Shift engine enable (active mode) |
| shift_hold | output | 1 | Shift engine hold (frozen mode) |
| side_clr | output | 1 | One-cycle clear for FIFOs, counters and status flags |

## Verification
The software-reset strobe and a mode write can land in the same cycle. The bench provokes this twice: once while the settle flag is low, with a write to active mode, and once from a settled frozen mode, again with a write to active mode. In both cases the expected result is idle, a settle flag of 0, a clear pulse and a fresh full-length settle window. Any trace of the write, such as the active mode or a missing clear, counts as a failure.

// File: rtl/opstate_pkg.sv
package opstate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GO   = 2'd1,
        ST_CLR  = 2'd2,
        ST_HOLD = 2'd3
    } op_code_e;

    typedef struct packed {
        logic     take;
        op_code_e nxt;
        logic     clr;
    } dec_t;

    function automatic logic is_steady(input op_code_e c);
        return c != ST_CLR;
    endfunction

endpackage

// File: rtl/opstate_settle.sv
module opstate_settle #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign ready = (cnt == '0);

    // R3: a started window always shows busy on the next cycle
    p_busy_after_start_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready);

endmodule

// File: rtl/opstate_decode.sv
module opstate_decode
    import opstate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  op_code_e cur,
    input  logic     ready,
    input  logic     req_we,
    input  logic [1:0] req_code,
    input  logic     sw_hit,
    output dec_t     dec
);
    logic     armed_q, armed_n;
    op_code_e code;

    assign code = op_code_e'(req_code);

    always_comb begin
        dec     = '0;
        dec.nxt = cur;
        armed_n = armed_q;
        if (sw_hit) begin
            dec.take = 1'b1;
            dec.nxt  = ST_IDLE;
            dec.clr  = 1'b1;
            armed_n  = 1'b0;
        end else if (req_we && ready) begin
            if (cur == ST_HOLD) begin
                if (code == ST_CLR) begin
                    if (armed_q) begin
                        dec.take = 1'b1;
                        dec.nxt  = ST_IDLE;
                        dec.clr  = 1'b1;
                        armed_n  = 1'b0;
                    end else begin
                        armed_n  = 1'b1;
                    end
                end else begin
                    armed_n = 1'b0;
                    if (code != ST_IDLE) begin
                        dec.take = 1'b1;
                        dec.nxt  = code;
                    end
                end
            end else if (is_steady(code)) begin
                dec.take = 1'b1;
                dec.nxt  = code;
                dec.clr  = (code == ST_IDLE) && (cur != ST_IDLE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= armed_n;
    end

    // R6: frozen mode cannot reach idle without an armed exit or a software reset
    p_pause_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_HOLD && !armed_q && !sw_hit) |=> (cur != ST_IDLE));

    // R4: while settling, nothing but a software reset changes the mode
    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (!ready && !sw_hit) |=> $stable(cur));

endmodule

// File: rtl/opstate_core.sv
module opstate_core
    import opstate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dec_t     dec,
    output op_code_e cur,
    output logic     shift_en,
    output logic     shift_hold,
    output logic     side_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= ST_IDLE;
            side_clr <= 1'b0;
        end else begin
            side_clr <= dec.clr;
            if (dec.take) cur <= dec.nxt;
        end
    end

    assign shift_en   = (cur == ST_GO);
    assign shift_hold = (cur == ST_HOLD);

    // R1: the clear code is never a held mode
    p_no_clear_state_r1: assert property (@(posedge clk) disable iff (rst)
        cur != ST_CLR);

    // R10: shifting and holding never overlap
    p_enables_r10: assert property (@(posedge clk) disable iff (rst)
        !(shift_en && shift_hold));

    // R9: the side clear only accompanies idle
    p_clr_in_idle_r9: assert property (@(posedge clk) disable iff (rst)
        side_clr |-> (cur == ST_IDLE));

endmodule

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
    import opstate_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_we,
    input  logic [1:0] req_code,
    input  logic       swrst_we,
    input  logic       swrst_bit,
    output logic [2:0] stat_rd,
    output logic       shift_en,
    output logic       shift_hold,
    output logic       side_clr
);
    logic     ready;
    logic     sw_hit;
    dec_t     dec;
    op_code_e cur;

    assign sw_hit = swrst_we && swrst_bit;

    opstate_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur),
        .ready    (ready),
        .req_we   (req_we),
        .req_code (req_code),
        .sw_hit   (sw_hit),
        .dec      (dec)
    );

    opstate_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (dec.take),
        .ready (ready)
    );

    opstate_core u_core (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .cur        (cur),
        .shift_en   (shift_en),
        .shift_hold (shift_hold),
        .side_clr   (side_clr)
    );

    assign stat_rd = {ready, cur};

    // R8: a software reset lands in idle with a clear and a busy flag
    p_sw_reset_r8: assert property (@(posedge clk) disable iff (rst)
        (swrst_we && swrst_bit) |=> (stat_rd == 3'b000 && side_clr));

    // R5: a clear code outside frozen mode leaves the readout alone
    p_clear_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (req_we && req_code == 2'd2 && stat_rd[2] && stat_rd[1:0] != 2'd3
         && !(swrst_we && swrst_bit)) |=> (stat_rd == $past(stat_rd)));

endmodule

// File: tb/opstate_ctrl_test.sv
`timescale 1ns/1ps
module opstate_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_we;
    logic [1:0] req_code;
    logic       swrst_we;
    logic       swrst_bit;
    logic [2:0] stat_rd;
    logic       shift_en, shift_hold, side_clr;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [3:0] q_exp[$];   // {valid, mode[1:0], clr}
    string      q_tag[$];

    always #2 clk = ~clk;

    opstate_ctrl #(.SETTLE_CYC(4)) uut (
        .clk(clk), .rst(rst), .req_we(req_we), .req_code(req_code),
        .swrst_we(swrst_we), .swrst_bit(swrst_bit), .stat_rd(stat_rd),
        .shift_en(shift_en), .shift_hold(shift_hold), .side_clr(side_clr)
    );

    // monitor: compares outputs one time unit after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q_exp.size() > 0) begin
                logic [3:0] e;
                string      t;
                logic       e_en, e_hold;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                e_en   = (e[2:1] == 2'd1);
                e_hold = (e[2:1] == 2'd3);
                n_run++;
                if (stat_rd !== e[3:1] || side_clr !== e[0] ||
                    shift_en !== e_en || shift_hold !== e_hold) begin
                    n_fail++;
                    $display("FAIL %s: stat=%b en=%b hold=%b clr=%b expected stat=%b en=%b hold=%b clr=%b",
                             t, stat_rd, shift_en, shift_hold, side_clr,
                             e[3:1], e_en, e_hold, e[0]);
                end
            end
        end
    end

    task automatic cyc(input logic we, input logic [1:0] code,
                       input logic swe, input logic sbit);
        @(negedge clk);
        req_we = we; req_code = code; swrst_we = swe; swrst_bit = sbit;
        @(posedge clk);
    endtask

    task automatic chk(input logic [1:0] st, input logic v,
                       input logic clr, input string tag);
        q_exp.push_back({v, st, clr});
        q_tag.push_back(tag);
    endtask

    task automatic settle(input int lows, input logic [1:0] st, input string tag);
        for (int i = 0; i < lows; i++) begin
            cyc(0, 2'd0, 0, 0);
            chk(st, 1'b0, 1'b0, tag);
        end
        cyc(0, 2'd0, 0, 0);
        chk(st, 1'b1, 1'b0, tag);
    endtask

    initial begin
        rst = 1'b1; req_we = 0; req_code = 0; swrst_we = 0; swrst_bit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        cyc(0, 2'd0, 0, 0); chk(2'd0, 1, 0, "R1 reset state");

        // R2/R3: idle -> active, full settle window
        cyc(1, 2'd1, 0, 0); chk(2'd1, 0, 0, "R2 to active");
        settle(3, 2'd1, "R3 window");

        // R4: write during settle ignored, window not stretched
        cyc(1, 2'd3, 0, 0); chk(2'd3, 0, 0, "R2 to frozen");
        cyc(1, 2'd1, 0, 0); chk(2'd3, 0, 0, "R4 busy write ignored");
        settle(2, 2'd3, "R4 window unchanged");

        // R6: double clear exits frozen mode
        cyc(1, 2'd2, 0, 0); chk(2'd3, 1, 0, "R6 single clear");
        cyc(0, 2'd0, 0, 0); chk(2'd3, 1, 0, "R6 armed holds");
        cyc(1, 2'd2, 0, 0); chk(2'd0, 0, 1, "R6 second clear / R9 pulse");
        cyc(0, 2'd0, 0, 0); chk(2'd0, 0, 0, "R9 one cycle");
        settle(2, 2'd0, "R3 after exit");

        // R5: clear code ignored in idle and active
        cyc(1, 2'd2, 0, 0); chk(2'd0, 1, 0, "R5 idle");
        cyc(1, 2'd1, 0, 0); chk(2'd1, 0, 0, "R2 to active");
        settle(3, 2'd1, "R3");
        cyc(1, 2'd2, 0, 0); chk(2'd1, 1, 0, "R5 active");

        // R9: active -> idle pulses; idle -> idle does not
        cyc(1, 2'd0, 0, 0); chk(2'd0, 0, 1, "R9 active to idle");
        settle(3, 2'd0, "R3");
        cyc(1, 2'd0, 0, 0); chk(2'd0, 0, 0, "R9 idle rewrite no pulse");
        settle(3, 2'd0, "R3");

        // R7: frozen-mode guards and disarm
        cyc(1, 2'd3, 0, 0); chk(2'd3, 0, 0, "R2 to frozen");
        settle(3, 2'd3, "R3");
        cyc(1, 2'd0, 0, 0); chk(2'd3, 1, 0, "R7 direct idle ignored");
        cyc(1, 2'd2, 0, 0); chk(2'd3, 1, 0, "R7 arm");
        cyc(1, 2'd1, 0, 0); chk(2'd1, 0, 0, "R7 disarm to active");
        settle(3, 2'd1, "R3");
        cyc(1, 2'd3, 0, 0); chk(2'd3, 0, 0, "R2 to frozen");
        settle(3, 2'd3, "R3");
        cyc(1, 2'd2, 0, 0); chk(2'd3, 1, 0, "R7 rearm needs two");
        cyc(1, 2'd2, 0, 0); chk(2'd0, 0, 1, "R7 exit after rearm");
        settle(3, 2'd0, "R3");

        // R8: software reset
        cyc(1, 2'd1, 0, 0); chk(2'd1, 0, 0, "R2 to active");
        settle(3, 2'd1, "R3");
        cyc(0, 2'd0, 1, 0); chk(2'd1, 1, 0, "R8 bit zero no effect");
        cyc(1, 2'd3, 0, 0); chk(2'd3, 0, 0, "R2 to frozen");
        cyc(1, 2'd1, 1, 1); chk(2'd0, 0, 1, "R8 busy with write");
        settle(3, 2'd0, "R8 fresh window");
        cyc(1, 2'd3, 0, 0); chk(2'd3, 0, 0, "R2 to frozen");
        settle(3, 2'd3, "R3");
        cyc(1, 2'd1, 1, 1); chk(2'd0, 0, 1, "R8 overrides write");
        settle(3, 2'd0, "R8 fresh window");
        cyc(0, 2'd0, 1, 1); chk(2'd0, 0, 1, "R8 in idle / R9");
        settle(3, 2'd0, "R8 fresh window");

        cyc(0, 2'd0, 0, 0);
        @(posedge clk); #2;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule